// File: doc/BRIEF.md
# Cluster Performance Monitor Counter Unit

This block counts activity in a processor cluster. It offers a set of 32-bit event counters, one to thirty-one of them, fixed by a parameter. It also has one 64-bit cycle counter that advances on every clock while it is enabled. Each event counter has a select register that chooses which of 64 common event inputs feeds it. One event code is kept for chaining, and a counter that selects it never advances.

Software works the block through a word-addressed register port. The port offers a global control word, separate set and clear registers for the count-enable and interrupt-enable masks, and an overflow status word that clears itself when read. Two read-only words report which common events the cluster supports. The single interrupt output is a level. It stays high while any overflowed counter also has its interrupt enabled.

All three masks use the same bit layout. Bit i belongs to event counter i, and bit 31 belongs to the cycle counter.

Top module: `clus_pmu`

## Requirements
- R1: After synchronous reset, all counters, select registers, masks and overflow status are zero, the global enable is off, `irq_o` is 0 and `rdata_o` is 0.
- R2: The control word at address 0x00 reads as: global enable in bit 0; 0 in bits [10:1]; the counter count in bits [15:11]; the identification code in [23:16]; the implementer code in [31:24]. Only bit 0 of a write is stored.
- R3: Event counter i sits at address 0x20+i and its select register at 0x40+i. The counter advances by one on a clock edge when the global enable is on, its count-enable bit is set, and the event input named by its select register is high. Otherwise it holds its value.
- R4: A counter whose select register holds code 0x1e never advances, whatever its event inputs do.
- R5: Writing ones to address 0x01 sets count-enable bits, and writing ones to 0x02 clears them. Addresses 0x03 and 0x04 do the same for interrupt-enable bits. Reading either address of a pair returns the mask. Bits of counters that are not implemented always read 0.
- R6: A counter that goes from all ones to zero sets its overflow bit on that same edge. Event counter i uses bit i and the cycle counter uses bit 31.
- R7: A read of the overflow status at 0x05 returns the mask and clears it in the same access. An overflow that happens on that same edge stays set.
- R8: `irq_o` is the registered OR of (overflow status AND interrupt enable). It rises on the edge that sets the overflow bit and falls on the edge that clears the bit.
- R9: The cycle counter is 64 bits, read and written as low and high halves at 0x08 and 0x09. It advances every clock while the global enable and mask bit 31 are both set.
- R10: Writing a 1 to control bit 1 zeroes all event counters. Writing a 1 to control bit 2 zeroes the cycle counter. Both bits read back as 0.
- R11: Addresses 0x06 and 0x07 return the low and high words of the supported-event bitmap parameter. Bit n is set when common event n is present.
- R12: `rdata_o` changes only on the edge that follows a cycle with `rd_en_i` high, and then holds the word for the address read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 7 | Word address |
| wdata_i | input | 32 | Write data |
| evt_i | input | 64 | Common event inputs, one per code |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
Each counter is given its own select code, and event words are applied one cycle at a time. Some words hit one counter, some hit several, some hit only the chain code, and some arrive while counting is off. The final counts therefore show whether routing, the per-counter gate, the global gate and the chain exclusion each work on their own. The masks are written with bits outside the implemented range, which shows whether those bits are dropped. The cycle counter is preloaded to all ones, then enabled for one cycle with its interrupt on and again with it off. This separates setting the overflow bit from raising the interrupt, and shows that a status read clears both.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W    = 7;
  localparam int REG_W     = 32;
  localparam int EVT_CNT_W = 32;
  localparam int CYC_CNT_W = 64;
  localparam int SLOTS     = 32;
  localparam int CYC_SLOT  = 31;
  localparam int EVT_CHAIN = 30;

  localparam logic [ADDR_W-1:0] A_CTRL    = 7'h00;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 7'h01;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 7'h02;
  localparam logic [ADDR_W-1:0] A_IE_SET  = 7'h03;
  localparam logic [ADDR_W-1:0] A_IE_CLR  = 7'h04;
  localparam logic [ADDR_W-1:0] A_OVF     = 7'h05;
  localparam logic [ADDR_W-1:0] A_SUP_LO  = 7'h06;
  localparam logic [ADDR_W-1:0] A_SUP_HI  = 7'h07;
  localparam logic [ADDR_W-1:0] A_CYC_LO  = 7'h08;
  localparam logic [ADDR_W-1:0] A_CYC_HI  = 7'h09;
  localparam logic [ADDR_W-1:0] A_CNT     = 7'h20;
  localparam logic [ADDR_W-1:0] A_SEL     = 7'h40;
endpackage

// File: rtl/pmu_evt_cnt.sv
module pmu_evt_cnt
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 64,
  parameter int CNT_W   = EVT_CNT_W
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic [NUM_EVT-1:0]         evt_i,
  input  logic                       en_i,
  input  logic                       clr_i,
  input  logic                       sel_wr_i,
  input  logic [$clog2(NUM_EVT)-1:0] sel_d_i,
  input  logic                       cnt_wr_i,
  input  logic [CNT_W-1:0]           cnt_d_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [$clog2(NUM_EVT)-1:0] sel_o,
  output logic                       wrap_o
);
  localparam int EVT_W = $clog2(NUM_EVT);

  logic [EVT_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  // chain code is reserved: a counter pointed at it stays still
  assign hit = en_i && (sel_q != EVT_W'(EVT_CHAIN)) && evt_i[sel_q];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (sel_wr_i) sel_q <= sel_d_i;
      if (clr_i)         cnt_q <= '0;
      else if (cnt_wr_i) cnt_q <= cnt_d_i;
      else if (hit)      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wrap_o = hit && !clr_i && !cnt_wr_i && (&cnt_q);
  assign cnt_o  = cnt_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/pmu_cyc_cnt.sv
module pmu_cyc_cnt
  import pmu_pkg::*;
#(
  parameter int CNT_W = CYC_CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               wrap_o
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i)  cnt_q <= '0;
    else if (wr_lo_i)    cnt_q[HALF-1:0] <= wdata_i;
    else if (wr_hi_i)    cnt_q[CNT_W-1:HALF] <= wdata_i;
    else if (en_i)       cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = en_i && !clr_i && !wr_lo_i && !wr_hi_i && (&cnt_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/clus_pmu.sv
module clus_pmu
  import pmu_pkg::*;
#(
  parameter int          NUM_CNT     = 4,
  parameter int          NUM_EVT     = 64,
  parameter logic [7:0]  ID_CODE     = 8'h5A,
  parameter logic [7:0]  IMPL_CODE   = 8'hC3,
  parameter logic [63:0] EVT_SUPPORT = 64'h0000_00F0_3A02_0001
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               irq_o
);
  localparam int EVT_W = $clog2(NUM_EVT);
  localparam logic [REG_W-1:0] IMPL_MASK =
    (REG_W'(1) << CYC_SLOT) | ((REG_W'(1) << NUM_CNT) - REG_W'(1));

  logic                 glb_en_q, irq_q;
  logic [REG_W-1:0]     cnten_q, inten_q, ovf_q, rdata_q;
  logic [REG_W-1:0]     cnten_nx, inten_nx, ovf_nx, rd_mux;
  logic [SLOTS-1:0]     wrap_v;
  logic [EVT_CNT_W-1:0] cnt_arr [SLOTS];
  logic [EVT_W-1:0]     sel_arr [SLOTS];
  logic [CYC_CNT_W-1:0] cyc_q;
  logic                 wr_ctrl, evt_clr, cyc_clr, rd_ovf;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign evt_clr = wr_ctrl && wdata_i[1];
  assign cyc_clr = wr_ctrl && wdata_i[2];
  assign rd_ovf  = rd_en_i && (addr_i == A_OVF);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_CNT) begin : g_evt
      pmu_evt_cnt #(.NUM_EVT(NUM_EVT)) u_cnt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .evt_i    (evt_i),
        .en_i     (glb_en_q && cnten_q[g]),
        .clr_i    (evt_clr),
        .sel_wr_i (wr_en_i && (addr_i == A_SEL + ADDR_W'(g))),
        .sel_d_i  (wdata_i[EVT_W-1:0]),
        .cnt_wr_i (wr_en_i && (addr_i == A_CNT + ADDR_W'(g))),
        .cnt_d_i  (wdata_i),
        .cnt_o    (cnt_arr[g]),
        .sel_o    (sel_arr[g]),
        .wrap_o   (wrap_v[g])
      );
    end else if (g == CYC_SLOT) begin : g_cyc
      pmu_cyc_cnt u_cyc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (glb_en_q && cnten_q[CYC_SLOT]),
        .clr_i   (cyc_clr),
        .wr_lo_i (wr_en_i && (addr_i == A_CYC_LO)),
        .wr_hi_i (wr_en_i && (addr_i == A_CYC_HI)),
        .wdata_i (wdata_i),
        .cnt_o   (cyc_q),
        .wrap_o  (wrap_v[g])
      );
      assign cnt_arr[g] = '0;
      assign sel_arr[g] = '0;
    end else begin : g_none
      assign cnt_arr[g] = '0;
      assign sel_arr[g] = '0;
      assign wrap_v[g]  = 1'b0;
    end
  end

  always_comb begin
    cnten_nx = cnten_q;
    inten_nx = inten_q;
    if (wr_en_i && addr_i == A_EN_SET) cnten_nx = cnten_q | (wdata_i & IMPL_MASK);
    if (wr_en_i && addr_i == A_EN_CLR) cnten_nx = cnten_q & ~wdata_i;
    if (wr_en_i && addr_i == A_IE_SET) inten_nx = inten_q | (wdata_i & IMPL_MASK);
    if (wr_en_i && addr_i == A_IE_CLR) inten_nx = inten_q & ~wdata_i;
    ovf_nx = (rd_ovf ? '0 : ovf_q) | wrap_v;
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i[6:5] == 2'b01) rd_mux = cnt_arr[addr_i[4:0]];
    else if (addr_i[6:5] == 2'b10) rd_mux = REG_W'(sel_arr[addr_i[4:0]]);
    else begin
      case (addr_i)
        A_CTRL:             rd_mux = {IMPL_CODE, ID_CODE, 5'(NUM_CNT), 10'd0, glb_en_q};
        A_EN_SET, A_EN_CLR: rd_mux = cnten_q;
        A_IE_SET, A_IE_CLR: rd_mux = inten_q;
        A_OVF:              rd_mux = ovf_q;
        A_SUP_LO:           rd_mux = EVT_SUPPORT[31:0];
        A_SUP_HI:           rd_mux = EVT_SUPPORT[63:32];
        A_CYC_LO:           rd_mux = cyc_q[31:0];
        A_CYC_HI:           rd_mux = cyc_q[63:32];
        default:            rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      glb_en_q <= 1'b0;
      cnten_q  <= '0;
      inten_q  <= '0;
      ovf_q    <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_ctrl) glb_en_q <= wdata_i[0];
      cnten_q <= cnten_nx;
      inten_q <= inten_nx;
      ovf_q   <= ovf_nx;
      irq_q   <= |(ovf_nx & inten_nx);
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic                 wr_en_i,
  input logic                 rd_en_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [REG_W-1:0]     rdata_o,
  input logic                 irq_o,
  input logic                 glb_en,
  input logic [REG_W-1:0]     cnten,
  input logic [REG_W-1:0]     inten,
  input logic [REG_W-1:0]     ovf,
  input logic [CYC_CNT_W-1:0] cyc
);
  localparam logic [REG_W-1:0] IMPL_MASK =
    (REG_W'(1) << CYC_SLOT) | ((REG_W'(1) << NUM_CNT) - REG_W'(1));

  AST_IRQ_TRACKS: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o == |(ovf & inten)); // R8
  AST_OVF_READ: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && addr_i == A_OVF) |=> rdata_o == $past(ovf)); // R7
  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    ((cnten | inten | ovf) & ~IMPL_MASK) == '0); // R5
  AST_CYC_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!glb_en && !wr_en_i) |=> $stable(cyc)); // R9
  AST_CYC_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ovf[CYC_SLOT]) |-> cyc == '0); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_en_i |=> $stable(rdata_o)); // R12
endmodule

bind clus_pmu pmu_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .glb_en  (glb_en_q),
  .cnten   (cnten_q),
  .inten   (inten_q),
  .ovf     (ovf_q),
  .cyc     (cyc_q)
);

// File: tb/clus_pmu_tb.sv
module clus_pmu_tb;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TICK = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [6:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,   4'd2,  7'h00, 32'h0,        32'hC35A2000}, // R2 control fields
    '{OP_RD,   4'd11, 7'h06, 32'h0,        32'h3A020001}, // R11
    '{OP_RD,   4'd11, 7'h07, 32'h0,        32'h000000F0}, // R11
    '{OP_WR,   4'd3,  7'h40, 32'h3,        32'h0},
    '{OP_WR,   4'd3,  7'h41, 32'h5,        32'h0},
    '{OP_WR,   4'd4,  7'h42, 32'h1E,       32'h0},        // R4 chain code
    '{OP_WR,   4'd3,  7'h43, 32'h7,        32'h0},
    '{OP_RD,   4'd3,  7'h42, 32'h0,        32'h0000001E}, // R3
    '{OP_WR,   4'd5,  7'h01, 32'h0000000F, 32'h0},
    '{OP_WR,   4'd5,  7'h01, 32'h7FFFFFF0, 32'h0},
    '{OP_RD,   4'd5,  7'h01, 32'h0,        32'h0000000F}, // R5 unimplemented dropped
    '{OP_TICK, 4'd3,  7'h00, 32'hFFFFFFFF, 32'h0},
    '{OP_RD,   4'd3,  7'h20, 32'h0,        32'h0},        // R3 global off
    '{OP_WR,   4'd2,  7'h00, 32'h1,        32'h0},
    '{OP_RD,   4'd2,  7'h00, 32'h0,        32'hC35A2001}, // R2
    '{OP_TICK, 4'd3,  7'h00, 32'h00000008, 32'h0},
    '{OP_TICK, 4'd3,  7'h00, 32'h00000028, 32'h0},
    '{OP_TICK, 4'd4,  7'h00, 32'h40000000, 32'h0},
    '{OP_TICK, 4'd3,  7'h00, 32'hFFFFFFFF, 32'h0},
    '{OP_WR,   4'd5,  7'h02, 32'h00000002, 32'h0},
    '{OP_RD,   4'd5,  7'h02, 32'h0,        32'h0000000D}, // R5
    '{OP_TICK, 4'd3,  7'h00, 32'h000000FF, 32'h0},
    '{OP_WR,   4'd2,  7'h00, 32'h0,        32'h0},
    '{OP_RD,   4'd3,  7'h20, 32'h0,        32'h4},        // R3
    '{OP_RD,   4'd3,  7'h21, 32'h0,        32'h2},        // R3 per-counter gate
    '{OP_RD,   4'd4,  7'h22, 32'h0,        32'h0},        // R4
    '{OP_RD,   4'd3,  7'h23, 32'h0,        32'h2},        // R3
    '{OP_WR,   4'd6,  7'h21, 32'hFFFFFFFF, 32'h0},
    '{OP_WR,   4'd6,  7'h01, 32'h00000002, 32'h0},
    '{OP_WR,   4'd6,  7'h03, 32'h00000002, 32'h0},
    '{OP_WR,   4'd6,  7'h00, 32'h1,        32'h0},
    '{OP_TICK, 4'd6,  7'h00, 32'h00000020, 32'h0},
    '{OP_WR,   4'd6,  7'h00, 32'h0,        32'h0},
    '{OP_RD,   4'd6,  7'h21, 32'h0,        32'h0},        // R6 wrapped
    '{OP_RD,   4'd7,  7'h05, 32'h0,        32'h00000002}, // R7
    '{OP_RD,   4'd7,  7'h05, 32'h0,        32'h0},        // R7 cleared
    '{OP_RD,   4'd5,  7'h03, 32'h0,        32'h00000002}, // R5
    '{OP_WR,   4'd5,  7'h04, 32'h00000002, 32'h0},
    '{OP_RD,   4'd5,  7'h04, 32'h0,        32'h0},        // R5
    '{OP_WR,   4'd10, 7'h00, 32'h2,        32'h0},
    '{OP_RD,   4'd10, 7'h20, 32'h0,        32'h0},        // R10
    '{OP_RD,   4'd10, 7'h23, 32'h0,        32'h0},        // R10
    '{OP_RD,   4'd2,  7'h00, 32'h0,        32'hC35A2000}, // R2
    '{OP_RD,   4'd12, 7'h24, 32'h0,        32'h0}         // R12 unmapped slot
  };

  logic        clk = 1'b0;
  logic        rst_i = 1'b1;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [63:0] evt_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int          n_chk = 0, n_fail = 0, cyc_n = 0;

  always #4 clk = ~clk;

  clus_pmu u_dut (
    .clk_i(clk), .rst_i(rst_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .evt_i(evt_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (cyc_n > 20000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles exp done", cyc_n);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string req);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    check(req, rdata_o, e);
  endtask

  task automatic tick(input logic [31:0] pat);
    evt_i = {32'h0, pat};
    @(negedge clk);
    evt_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_i = 1'b0;
    check("R1 irq", 32'(irq_o), 32'h0);
    check("R1 rdata", rdata_o, 32'h0);
    rd(7'h05, 32'h0, "R1 ovf");
    rd(7'h01, 32'h0, "R1 enable mask");
    rd(7'h08, 32'h0, "R1 cycle");

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR:   wr(VEC[i].addr, VEC[i].data);
        OP_TICK: tick(VEC[i].data);
        default: rd(VEC[i].addr, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
      endcase
    end

    // cycle counter wrap with interrupt enabled
    wr(7'h08, 32'hFFFFFFFF);
    wr(7'h09, 32'hFFFFFFFF);
    wr(7'h01, 32'h80000000);
    wr(7'h03, 32'h80000000);
    check("R8 irq before wrap", 32'(irq_o), 32'h0);
    wr(7'h00, 32'h1);
    wr(7'h00, 32'h0);
    check("R8 irq after wrap", 32'(irq_o), 32'h1);
    rd(7'h08, 32'h0, "R6 cycle low wrapped");
    rd(7'h09, 32'h0, "R9 cycle high wrapped");
    rd(7'h05, 32'h80000000, "R7 cycle overflow bit");
    check("R8 irq after status read", 32'(irq_o), 32'h0);

    // exact cycle counting and cycle reset
    wr(7'h00, 32'h1);
    repeat (2) @(negedge clk);
    wr(7'h00, 32'h0);
    rd(7'h08, 32'h3, "R9 three cycles");
    @(negedge clk);
    check("R12 rdata holds", rdata_o, 32'h3);
    wr(7'h00, 32'h4);
    rd(7'h08, 32'h0, "R10 cycle reset");

    // overflow with interrupt masked
    wr(7'h04, 32'h80000000);
    wr(7'h08, 32'hFFFFFFFF);
    wr(7'h09, 32'hFFFFFFFF);
    wr(7'h00, 32'h1);
    wr(7'h00, 32'h0);
    check("R8 masked irq", 32'(irq_o), 32'h0);
    rd(7'h05, 32'h80000000, "R6 masked overflow");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule